// File: doc/BRIEF.md
# I2C Slave Byte Memory

This block is a two-wire (I2C) slave that sits in front of a byte-wide memory addressed by a 16-bit pointer. A bus master selects it with a 7-bit device address, loads a pointer as two bytes, and then writes or reads bytes one after another. The pointer steps forward by one after every byte and rolls over from 0xFFFF to 0x0000. Each write lands in the array within one bus bit time. The slave therefore never stretches the clock, never withholds an acknowledge for a busy phase, and can be addressed again as soon as a stop is seen.

SCL and SDA reach the block as raw pad levels. Each passes through a two-flop synchroniser clocked by a faster system clock, and edge logic on that clock finds the bus conditions. The block pulls SDA low only through `sda_oe`; the pad is open drain, with a pull-up outside the block. SCL is an input only. The parameter `ARRAY_AW` sets how many low pointer bits index the array. A value of 16 gives the full 64K x 8 store with every pointer bit decoded. Smaller values give a reduced array for cheap elaboration, and then the low `ARRAY_AW` pointer bits select the cell.

The only data path is the serial bus, and its pace is set entirely by the master's clock. There is no valid/ready stream and no back-pressure: the slave accepts every bit at bus speed.

Top module: `i2c_byte_mem`

## Requirements
- R1: After reset, `sda_oe` is 0 and the slave waits for a start condition, which is SDA falling while SCL is high.
- R2: The slave acknowledges a device address byte whose upper seven bits equal {4'b1010, dev_sel[2:0]}, sent most significant bit first. It acknowledges by driving SDA low during the ninth clock. Bit 0 of that byte selects read (1) or write (0).
- R3: When the device address does not match, the slave leaves SDA released and ignores the bus until the next start condition.
- R4: In write mode, the two bytes after the device address load the pointer, high byte first, and each of them is acknowledged.
- R5: Each data byte that follows in write mode is stored at the pointer and acknowledged, and then the pointer increments.
- R6: A read-mode device address with no preceding address phase returns bytes starting at the current pointer.
- R7: A repeated start (a start with no stop before it) restarts device-address reception. This means a write-mode address phase, then a repeated start, then a read-mode device address performs a random read.
- R8: The pointer increments after each byte read or written, and it wraps from 0xFFFF to 0x0000.
- R9: During a read, an acknowledge from the master (SDA low on the ninth clock) fetches the next byte. A no-acknowledge (SDA high) ends the burst, and SDA stays released until the next start condition.
- R10: A stop condition (SDA rising while SCL is high) or a start condition seen in the middle of a byte abandons that byte without storing it. A stop returns the slave to idle, and a start begins a new device address.
- R11: The slave only begins pulling SDA low while SCL is low, and it has no SCL output.
- R12: There is no busy state. A transaction that starts right after the stop that ends a write is acknowledged, and it reads back the value just written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad (the wired bus value) |
| dev_sel | input | 3 | Address-select straps, the low three bits of the device address |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The hardest situations to reach from the pins are the aborts in the middle of a byte. The stop or repeated start has to arrive after only a few data bits, while the shift register holds a partial byte and the slave is neither acknowledging nor transmitting. The bench reaches them with a bit-level master that can end a byte after any number of bits. It then reads the target cell back through a fresh random read to prove that nothing was stored, and it checks that the interrupted device still acknowledges its address afterwards. Pointer wraparound is reached by loading 0xFFFE and bursting across the boundary. The address match is swept over every pairing of strap value and requested address.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int PTR_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK
  } phase_t;

  typedef enum logic [1:0] {
    RL_DEV,
    RL_AHI,
    RL_ALO,
    RL_DATA
  } role_t;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din[g]};
      end
      assign dout[g] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2cm_cond.sv
module i2cm_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cm_array.sv
module i2cm_array #(
  parameter int AW      = 10,
  parameter int DW      = 8,
  parameter int FULL_AW = 16
) (
  input  logic               clk,
  input  logic               we,
  input  logic [FULL_AW-1:0] waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [FULL_AW-1:0] raddr,
  output logic [DW-1:0]      rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr[AW-1:0]] <= wdata;
  end

  assign rdata = cells[raddr[AW-1:0]];

  generate
    if (AW < FULL_AW) begin : g_fold
      logic unused_hi;
      assign unused_hi = ^{waddr[FULL_AW-1:AW], raddr[FULL_AW-1:AW]};
    end
  endgenerate
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [2:0]        dev_sel,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_waddr,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [PTR_W-1:0]  mem_raddr,
  output logic              sda_oe
);
  phase_t            phase;
  role_t             role;
  logic [2:0]        cnt;
  logic              byte_done;
  logic [BYTE_W-1:0] sreg;
  logic [BYTE_W-1:0] txreg;
  logic              rw;
  logic              m_nack;
  logic [PTR_W-1:0]  ptr;
  logic              dev_hit;

  assign dev_hit   = (sreg[7:1] == {DEV_TYPE, dev_sel});
  assign mem_raddr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      role      <= RL_DEV;
      cnt       <= '0;
      byte_done <= 1'b0;
      sreg      <= '0;
      txreg     <= '0;
      rw        <= 1'b0;
      m_nack    <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        phase     <= PH_RX;
        role      <= RL_DEV;
        cnt       <= '0;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_det) begin
        phase     <= PH_IDLE;
        byte_done <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        case (phase)
          PH_RX: begin
            if (scl_rise) begin
              sreg <= {sreg[6:0], sda_lvl};
              cnt  <= cnt + 3'd1;
              if (cnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              case (role)
                RL_DEV: begin
                  if (dev_hit) begin
                    rw     <= sreg[0];
                    sda_oe <= 1'b1;
                    phase  <= PH_RX_ACK;
                  end else begin
                    phase <= PH_IDLE;
                  end
                end
                RL_AHI: begin
                  ptr[15:8] <= sreg;
                  sda_oe    <= 1'b1;
                  phase     <= PH_RX_ACK;
                end
                RL_ALO: begin
                  ptr[7:0] <= sreg;
                  sda_oe   <= 1'b1;
                  phase    <= PH_RX_ACK;
                end
                default: begin
                  mem_we    <= 1'b1;
                  mem_waddr <= ptr;
                  mem_wdata <= sreg;
                  ptr       <= ptr + 16'd1;
                  sda_oe    <= 1'b1;
                  phase     <= PH_RX_ACK;
                end
              endcase
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (role == RL_DEV && rw) begin
                txreg  <= mem_rdata;
                sda_oe <= ~mem_rdata[7];
                ptr    <= ptr + 16'd1;
                role   <= RL_DATA;
                phase  <= PH_TX;
              end else begin
                sda_oe <= 1'b0;
                phase  <= PH_RX;
                case (role)
                  RL_DEV:  role <= RL_AHI;
                  RL_AHI:  role <= RL_ALO;
                  default: role <= RL_DATA;
                endcase
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                phase  <= PH_TX_ACK;
              end else begin
                sda_oe <= ~txreg[6];
                txreg  <= {txreg[6:0], 1'b0};
                cnt    <= cnt + 3'd1;
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              m_nack <= sda_lvl;
            end else if (scl_fall) begin
              if (!m_nack) begin
                txreg  <= mem_rdata;
                sda_oe <= ~mem_rdata[7];
                ptr    <= ptr + 16'd1;
                cnt    <= '0;
                phase  <= PH_TX;
              end else begin
                phase <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3: an idle slave never holds the bus
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_IDLE |-> !sda_oe);

  // R10: a stop condition always lands in idle with SDA released
  p_stop_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det && !start_det |=> phase == PH_IDLE && !sda_oe);

  // R7: a start condition always restarts device-address reception
  p_start_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> phase == PH_RX && role == RL_DEV && cnt == 3'd0);

  // R11: SDA is only pulled low while SCL is low
  p_drive_when_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  // R9: the slave listens during the master's acknowledge slot
  p_txack_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_TX_ACK |-> !sda_oe);

  // R5, R8: every stored byte leaves the pointer one past it, modulo 2^16
  p_write_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ptr == 16'(mem_waddr + 16'd1));
endmodule

// File: rtl/i2c_byte_mem.sv
module i2c_byte_mem #(
  parameter int ARRAY_AW    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] dev_sel,
  output logic       sda_oe
);
  import i2cm_pkg::*;

  logic [1:0]        pad_s;
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              mem_we;
  logic [PTR_W-1:0]  mem_waddr, mem_raddr;
  logic [BYTE_W-1:0] mem_wdata, mem_rdata;

  i2cm_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({sda_i, scl_i}),
    .dout (pad_s)
  );

  assign scl_s = pad_s[0];
  assign sda_s = pad_s[1];

  i2cm_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cm_engine u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_s),
    .sda_lvl  (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .dev_sel  (dev_sel),
    .mem_rdata(mem_rdata),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr),
    .sda_oe   (sda_oe)
  );

  i2cm_array #(.AW(ARRAY_AW), .DW(BYTE_W), .FULL_AW(PTR_W)) u_array (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(mem_raddr),
    .rdata(mem_rdata)
  );
endmodule

// File: tb/sim_i2c_byte_mem.sv
`timescale 1ns/1ps
module sim_i2c_byte_mem;
  localparam int CLK_PERIOD = 10;
  localparam int QTR = 6;
  localparam int WATCHDOG = 180000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic [2:0] dev_sel = 3'd0;
  logic       sda_oe;
  logic       sda_bus;
  int checks = 0;
  int errors = 0;
  int r11_viol = 0;
  bit finished = 1'b0;

  assign sda_bus = !(m_low || sda_oe);

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_mem #(.ARRAY_AW(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .dev_sel(dev_sel), .sda_oe(sda_oe)
  );

  always @(posedge sda_oe) if (scl) r11_viol++;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 5);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic b_start();
    m_low = 0; scl = 1; wq(); m_low = 1; wq(); scl = 0; wq();
  endtask

  task automatic b_rstart();
    m_low = 0; wq(); scl = 1; wq(); m_low = 1; wq(); scl = 0; wq();
  endtask

  task automatic b_stop();
    m_low = 1; wq(); scl = 1; wq(); m_low = 0; wq(); wq();
  endtask

  task automatic send_bit(input bit b);
    m_low = !b; wq(); scl = 1; wq(); wq(); scl = 0; wq();
  endtask

  task automatic send_byte(input logic [7:0] d, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    m_low = 0; wq(); scl = 1; wq(); ack = !sda_bus; wq(); scl = 0; wq();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    m_low = 0;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1; wq(); d = {d[6:0], sda_bus}; wq(); scl = 0;
    end
    m_low = give_ack; wq(); scl = 1; wq(); wq(); scl = 0; wq(); m_low = 0;
  endtask

  // write-mode device address plus the two pointer bytes
  task automatic addr_phase(input logic [15:0] a, input string req);
    bit ack;
    send_byte({4'b1010, dev_sel, 1'b0}, ack); chk({req, " dev ack"}, ack, 1);
    send_byte(a[15:8], ack); chk("R4 addr hi ack", ack, 1);
    send_byte(a[7:0], ack);  chk("R4 addr lo ack", ack, 1);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    chk("R1 sda released in reset", sda_oe, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 sda released after reset", sda_oe, 0);

    // R2 / R3: every strap value against every requested address
    for (int s = 0; s < 8; s++) begin
      dev_sel = 3'(s);
      for (int t = 0; t < 8; t++) begin
        b_start();
        send_byte({4'b1010, 3'(t), 1'b0}, ack);
        chk((s == t) ? "R2 match ack" : "R3 mismatch no ack", ack, (s == t) ? 1 : 0);
        b_stop();
      end
      b_start();
      send_byte({4'b1011, 3'(s), 1'b0}, ack);
      chk("R3 wrong type no ack", ack, 0);
      b_stop();
    end
    dev_sel = 3'd5;

    // R3: the write after a mismatched address must not be stored
    b_start(); addr_phase(16'h0030, "R2"); send_byte(8'h3C, ack); b_stop();
    b_start();
    send_byte({4'b1010, 3'd2, 1'b0}, ack);
    send_byte(8'h00, ack); chk("R3 ignored byte no ack", ack, 0);
    send_byte(8'h30, ack); send_byte(8'hEE, ack);
    b_stop();
    b_start(); addr_phase(16'h0030, "R2"); b_rstart();
    send_byte({4'b1010, dev_sel, 1'b1}, ack);
    recv_byte(0, d); chk("R3 cell untouched", d, 8'h3C);
    b_stop();

    // R4 / R5: burst write of 16 bytes at 0x12F8
    b_start(); addr_phase(16'h12F8, "R4");
    for (int i = 0; i < 16; i++) begin
      send_byte(pat(i), ack); chk("R5 data ack", ack, 1);
    end
    b_stop();

    // R7: random read of the burst, then R9 no-ack release
    b_start(); addr_phase(16'h12F8, "R7"); b_rstart();
    send_byte({4'b1010, dev_sel, 1'b1}, ack); chk("R7 read dev ack", ack, 1);
    for (int i = 0; i < 16; i++) begin
      recv_byte(i != 15, d); chk("R5 R7 read data", d, pat(i));
    end
    recv_byte(0, d); chk("R9 released after no-ack", d, 8'hFF);
    b_stop();

    // R6: current-address read after an address-only write phase
    b_start(); addr_phase(16'h0050, "R6");
    send_byte(8'hA0, ack); send_byte(8'hA1, ack); b_stop();
    b_start(); addr_phase(16'h0050, "R6"); b_stop();
    b_start();
    send_byte({4'b1010, dev_sel, 1'b1}, ack); chk("R6 read dev ack", ack, 1);
    recv_byte(1, d); chk("R6 current read byte 0", d, 8'hA0);
    recv_byte(0, d); chk("R6 current read byte 1", d, 8'hA1);
    b_stop();

    // R8: wrap across 0xFFFF
    b_start(); addr_phase(16'hFFFE, "R8");
    for (int i = 0; i < 3; i++) send_byte(8'(8'hC1 + i), ack);
    b_stop();
    b_start(); addr_phase(16'hFFFE, "R8"); b_rstart();
    send_byte({4'b1010, dev_sel, 1'b1}, ack);
    for (int i = 0; i < 3; i++) begin
      recv_byte(i != 2, d); chk("R8 wrap read", d, 8'hC1 + i);
    end
    b_stop();
    b_start();
    send_byte({4'b1010, dev_sel, 1'b1}, ack);
    recv_byte(0, d); chk("R8 pointer at 0x0001", d, pat(9));
    b_stop();

    // R10: stop after four data bits
    b_start(); addr_phase(16'h0040, "R10"); send_byte(8'h11, ack); b_stop();
    b_start(); addr_phase(16'h0040, "R10");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    b_stop();
    chk("R10 idle after stop", sda_oe, 0);
    // R10: repeated start after three bits of the high address byte
    b_start();
    send_byte({4'b1010, dev_sel, 1'b0}, ack);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    b_rstart();
    addr_phase(16'h0040, "R10 restart");
    b_rstart();
    send_byte({4'b1010, dev_sel, 1'b1}, ack);
    recv_byte(0, d); chk("R10 aborted byte not stored", d, 8'h11);
    b_stop();

    // R12: new transaction right after a write stop
    b_start(); addr_phase(16'h0060, "R12"); send_byte(8'h77, ack); b_stop();
    b_start(); addr_phase(16'h0060, "R12"); b_rstart();
    send_byte({4'b1010, dev_sel, 1'b1}, ack); chk("R12 ack right after write", ack, 1);
    recv_byte(0, d); chk("R12 readback", d, 8'h77);
    b_stop();

    chk("R11 SDA only pulled while SCL low", r11_viol, 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule